// File: doc/BRIEF.md
# Circular queue index manager

This block holds the producer and consumer indices of a circular queue that lives in system memory and serves either as a command queue or as an event queue. The number of slots is a power of two chosen at run time through a log2 size field. Each index carries one bit more than the slot number. That extra bit is a wrap flag, so the full and empty conditions can be told apart without a separate counter.

Software programs the base address, the size and both indices through a simple 32-bit register port. Neighbouring logic pulses increment strobes when it consumes or produces an entry, and it can record a command error code in the consumer register. The block outputs full and empty flags, an event overflow flag and the byte addresses of the next entry to produce and to consume. The queue kind is a parameter: a command entry is 16 bytes wide and an event entry 32 bytes wide.

Top module: `cq_index_mgr`

## Requirements
- R1: After reset both indices read 0, the size field reads LOG2_RST (default 2), the error field reads 0, `empty_o` is 1 and `full_o` is 0.
- R2: Register offsets are SIZE 0x00, BASE_LO 0x04, BASE_HI 0x08, PROD 0x0C and CONS 0x10, and unmapped offsets read 0. The log2 size is written in SIZE bits 4:0 and is clamped to LOG2_MAX (default 19). The clamped value is what reads back.
- R3: A SIZE write whose clamped value differs from the current size clears both indices and the overflow flag. Rewriting the same size leaves them unchanged.
- R4: `empty_o` is 1 exactly when both indices, taken over their low log2size+1 bits, are equal.
- R5: `full_o` is 1 exactly when the slot bits (the low log2size bits) of the two indices match and their wrap bits (bit log2size) differ.
- R6: A producer increment adds one modulo 2^(log2size+1). The count passes back through zero and the wrap bit toggles each time the slot number wraps.
- R7: A consumer increment changes only the index bits of CONS. The 7-bit error field at CONS bits 30:24 is kept.
- R8: A pulse on `err_we_i` writes `err_code_i` (0 none, 1 illegal command, 2 abort, 3 invalidate-sync error), zero-extended, into CONS bits 30:24.
- R9: A producer increment while the queue is full is ignored. In an event queue it also sets PROD bit 31 and `overflow_o`. In a command queue PROD bit 31 always reads 0.
- R10: A consumer increment while the queue is empty is ignored.
- R11: An entry address is the 48-bit base with bits 4:0 cleared (base bits 63:48 are ignored), plus the entry size (16 for command, 32 for event) times the slot number of the index.
- R12: A PROD or CONS write stores the written index masked to log2size+1 bits. In an event queue a PROD write also loads the overflow flag from bit 31. A CONS write leaves the error field unchanged. A write takes priority over an increment of the same index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| prod_inc_i | input | 1 | Advance the producer index |
| cons_inc_i | input | 1 | Advance the consumer index |
| err_we_i | input | 1 | Record an error code in CONS |
| err_code_i | input | 2 | Error code to record |
| full_o | output | 1 | Queue full |
| empty_o | output | 1 | Queue empty |
| overflow_o | output | 1 | Event overflow flag (always 0 for a command queue) |
| prod_addr_o | output | ADDR_W | Byte address of the next entry to produce |
| cons_addr_o | output | ADDR_W | Byte address of the next entry to consume |

## Verification
The bench builds two copies side by side on the same stimulus: one with KIND set to event, so entries are 32 bytes and the overflow bit is live, and one with KIND set to command, so entries are 16 bytes and bit 31 is always 0. Both keep LOG2_MAX at 19 and LOG2_RST at 2. A four-slot queue therefore fills, overflows and wraps within a few strobes. Writing a size of 31 reaches the clamp, and resizing to sixteen slots shows the same offsets scaled by the two entry sizes.

// File: rtl/cq_pkg.sv
package cq_pkg;
  typedef enum logic {CQ_KIND_CMD = 1'b0, CQ_KIND_EVT = 1'b1} cq_kind_e;

  typedef enum logic [1:0] {
    CQ_ERR_NONE    = 2'd0,
    CQ_ERR_ILLEGAL = 2'd1,
    CQ_ERR_ABORT   = 2'd2,
    CQ_ERR_SYNC    = 2'd3
  } cq_err_e;

  localparam logic [7:0] OFS_SIZE    = 8'h00;
  localparam logic [7:0] OFS_BASE_LO = 8'h04;
  localparam logic [7:0] OFS_BASE_HI = 8'h08;
  localparam logic [7:0] OFS_PROD    = 8'h0C;
  localparam logic [7:0] OFS_CONS    = 8'h10;

  localparam int unsigned SIZE_FW = 5;   // log2 size field width
  localparam int unsigned ERR_LSB = 24;
  localparam int unsigned ERR_W   = 7;
  localparam int unsigned BASE_ALIGN = 5;

  function automatic int unsigned entry_bytes(cq_kind_e k);
    return (k == CQ_KIND_EVT) ? 32 : 16;
  endfunction
endpackage

// File: rtl/cq_ptr.sv
module cq_ptr #(
  parameter int unsigned IDX_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_val_i,
  input  logic             inc_i,
  input  logic [IDX_W-1:0] wim_i,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_o <= '0;
    else if (clr_i) idx_o <= '0;
    else if (wr_i)  idx_o <= wr_val_i & wim_i;
    else if (inc_i) idx_o <= (idx_o + IDX_W'(1)) & wim_i;
  end
endmodule

// File: rtl/cq_flags.sv
module cq_flags #(
  parameter int unsigned IDX_W = 20
) (
  input  logic [IDX_W-1:0] prod_i,
  input  logic [IDX_W-1:0] cons_i,
  input  logic [IDX_W-1:0] wm_i,
  input  logic [IDX_W-1:0] wim_i,
  output logic             full_o,
  output logic             empty_o
);
  logic [IDX_W-1:0] diff;
  assign diff    = (prod_i ^ cons_i) & wim_i;
  assign empty_o = (diff == '0);
  assign full_o  = (diff == wm_i);
endmodule

// File: rtl/cq_addr.sv
module cq_addr #(
  parameter int unsigned ADDR_W      = 48,
  parameter int unsigned IDX_W       = 20,
  parameter int unsigned ENTRY_BYTES = 32
) (
  input  logic [ADDR_W-1:cq_pkg::BASE_ALIGN] base_i,
  input  logic [IDX_W-1:0]                   idx_i,
  input  logic [IDX_W-1:0]                   slot_mask_i,
  output logic [ADDR_W-1:0]                  addr_o
);
  localparam int unsigned ENTRY_SH = $clog2(ENTRY_BYTES);

  logic [ADDR_W-1:0] base_m, offs;
  assign base_m = {base_i, {cq_pkg::BASE_ALIGN{1'b0}}};
  assign offs   = ADDR_W'(idx_i & slot_mask_i) << ENTRY_SH;
  assign addr_o = base_m + offs;
endmodule

// File: rtl/cq_index_mgr.sv
module cq_index_mgr #(
  parameter cq_pkg::cq_kind_e KIND = cq_pkg::CQ_KIND_EVT,
  parameter int unsigned LOG2_MAX  = 19,
  parameter int unsigned LOG2_RST  = 2,
  parameter int unsigned ADDR_W    = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              prod_inc_i,
  input  logic              cons_inc_i,
  input  logic              err_we_i,
  input  logic [1:0]        err_code_i,
  output logic              full_o,
  output logic              empty_o,
  output logic              overflow_o,
  output logic [ADDR_W-1:0] prod_addr_o,
  output logic [ADDR_W-1:0] cons_addr_o
);
  import cq_pkg::*;

  localparam int unsigned IDX_W       = LOG2_MAX + 1;
  localparam int unsigned ENTRY_BYTES = entry_bytes(KIND);

  logic [SIZE_FW-1:0] l2_q, l2_new;
  logic [31:0]        base_lo_q, base_hi_q;
  logic [ERR_W-1:0]   err_q;
  logic               ovf_q;
  logic [IDX_W-1:0]   prod_idx, cons_idx, wm, wim, slot_mask;
  logic               wr_size, wr_prod, wr_cons, size_chg;
  logic               prod_ok, cons_ok;
  logic [63:0]        base_full;

  assign wr_size  = reg_we_i && (reg_addr_i == OFS_SIZE);
  assign wr_prod  = reg_we_i && (reg_addr_i == OFS_PROD);
  assign wr_cons  = reg_we_i && (reg_addr_i == OFS_CONS);
  assign l2_new   = (reg_wdata_i[SIZE_FW-1:0] > SIZE_FW'(LOG2_MAX)) ?
                    SIZE_FW'(LOG2_MAX) : reg_wdata_i[SIZE_FW-1:0];
  assign size_chg = wr_size && (l2_new != l2_q);

  assign wm        = IDX_W'(1) << l2_q;
  assign wim       = (wm << 1) - IDX_W'(1);
  assign slot_mask = wm - IDX_W'(1);

  assign prod_ok = prod_inc_i && !full_o;
  assign cons_ok = cons_inc_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l2_q      <= SIZE_FW'(LOG2_RST);
      base_lo_q <= '0;
      base_hi_q <= '0;
      err_q     <= '0;
    end else begin
      if (wr_size) l2_q <= l2_new;
      if (reg_we_i && reg_addr_i == OFS_BASE_LO) base_lo_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == OFS_BASE_HI) base_hi_q <= reg_wdata_i;
      if (err_we_i) err_q <= ERR_W'(err_code_i);
    end
  end

  cq_ptr #(.IDX_W(IDX_W)) u_prod (
    .clk_i, .rst_ni, .clr_i(size_chg), .wr_i(wr_prod),
    .wr_val_i(reg_wdata_i[IDX_W-1:0]), .inc_i(prod_ok), .wim_i(wim),
    .idx_o(prod_idx)
  );

  cq_ptr #(.IDX_W(IDX_W)) u_cons (
    .clk_i, .rst_ni, .clr_i(size_chg), .wr_i(wr_cons),
    .wr_val_i(reg_wdata_i[IDX_W-1:0]), .inc_i(cons_ok), .wim_i(wim),
    .idx_o(cons_idx)
  );

  cq_flags #(.IDX_W(IDX_W)) u_flags (
    .prod_i(prod_idx), .cons_i(cons_idx), .wm_i(wm), .wim_i(wim),
    .full_o(full_o), .empty_o(empty_o)
  );

  generate
    if (KIND == CQ_KIND_EVT) begin : g_ovf
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  ovf_q <= 1'b0;
        else if (size_chg)            ovf_q <= 1'b0;
        else if (wr_prod)             ovf_q <= reg_wdata_i[31];
        else if (prod_inc_i && full_o) ovf_q <= 1'b1;
      end
    end else begin : g_no_ovf
      assign ovf_q = 1'b0;
    end
  endgenerate

  assign overflow_o = ovf_q;
  assign base_full  = {base_hi_q, base_lo_q};

  cq_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENTRY_BYTES(ENTRY_BYTES)) u_paddr (
    .base_i(base_full[ADDR_W-1:BASE_ALIGN]), .idx_i(prod_idx),
    .slot_mask_i(slot_mask), .addr_o(prod_addr_o)
  );

  cq_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENTRY_BYTES(ENTRY_BYTES)) u_caddr (
    .base_i(base_full[ADDR_W-1:BASE_ALIGN]), .idx_i(cons_idx),
    .slot_mask_i(slot_mask), .addr_o(cons_addr_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_SIZE:    reg_rdata_o = 32'(l2_q);
      OFS_BASE_LO: reg_rdata_o = base_lo_q;
      OFS_BASE_HI: reg_rdata_o = base_hi_q;
      OFS_PROD: begin
        reg_rdata_o     = 32'(prod_idx);
        reg_rdata_o[31] = ovf_q;
      end
      OFS_CONS: begin
        reg_rdata_o = 32'(cons_idx);
        reg_rdata_o[ERR_LSB+ERR_W-1:ERR_LSB] = err_q;
      end
      default:     reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cq_index_chk.sv
module cq_index_chk #(
  parameter int unsigned LOG2_MAX = 19,
  parameter int unsigned IDX_W    = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [7:0]       reg_addr_i,
  input logic             prod_inc_i,
  input logic             cons_inc_i,
  input logic             err_we_i,
  input logic             full_o,
  input logic             empty_o,
  input logic             overflow_o,
  input logic [IDX_W-1:0] prod_idx,
  input logic [IDX_W-1:0] cons_idx,
  input logic [6:0]       err_q,
  input logic [4:0]       l2_q
);
  p_flags_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  p_size_clamp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_q <= 5'(LOG2_MAX));

  p_resize_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(l2_q) |-> (prod_idx == '0 && cons_idx == '0 && !overflow_o));

  p_full_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prod_inc_i && full_o && !reg_we_i) |=> $stable(prod_idx));

  p_ovf_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(prod_inc_i && full_o) ||
                          $past(reg_we_i && reg_addr_i == cq_pkg::OFS_PROD));

  p_empty_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_inc_i && empty_o && !reg_we_i) |=> $stable(cons_idx));

  p_err_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_inc_i && !err_we_i) |=> $stable(err_q));
endmodule

bind cq_index_mgr cq_index_chk #(.LOG2_MAX(LOG2_MAX), .IDX_W(LOG2_MAX + 1)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .prod_inc_i(prod_inc_i), .cons_inc_i(cons_inc_i), .err_we_i(err_we_i),
  .full_o(full_o), .empty_o(empty_o), .overflow_o(overflow_o),
  .prod_idx(prod_idx), .cons_idx(cons_idx), .err_q(err_q), .l2_q(l2_q)
);

// File: tb/sim_cq_index_mgr.sv
module sim_cq_index_mgr;
  import cq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        pinc = 1'b0, cinc = 1'b0, ewe = 1'b0;
  logic [1:0]  ecode = '0;
  logic [31:0] rd0, rd1;
  logic        full0, empty0, ovf0, full1, empty1, ovf1;
  logic [47:0] pa0, ca0, pa1, ca1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [47:0] BASE_M = 48'hABCD_1234_5660;

  always #2 clk = ~clk;

  cq_index_mgr #(.KIND(CQ_KIND_EVT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rd0), .prod_inc_i(pinc),
    .cons_inc_i(cinc), .err_we_i(ewe), .err_code_i(ecode),
    .full_o(full0), .empty_o(empty0), .overflow_o(ovf0),
    .prod_addr_o(pa0), .cons_addr_o(ca0)
  );

  cq_index_mgr #(.KIND(CQ_KIND_CMD)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rd1), .prod_inc_i(pinc),
    .cons_inc_i(cinc), .err_we_i(ewe), .err_code_i(ecode),
    .full_o(full1), .empty_o(empty1), .overflow_o(ovf1),
    .prod_addr_o(pa1), .cons_addr_o(ca1)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); addr = a; #1;
  endtask

  task automatic pulse(input bit p, input bit c, input bit e, input logic [1:0] code);
    @(negedge clk); pinc = p; cinc = c; ewe = e; ecode = code;
    @(negedge clk); pinc = 1'b0; cinc = 1'b0; ewe = 1'b0;
  endtask

  task automatic t_reset;
    rd(OFS_SIZE); chk("R1 size", rd0, 32'd2);
    rd(OFS_PROD); chk("R1 prod", rd0, 0); chk("R1 prod cmd", rd1, 0);
    rd(OFS_CONS); chk("R1 cons", rd0, 0);
    chk("R1 empty", empty0, 1); chk("R1 full", full0, 0);
    rd(8'h40); chk("R2 unmapped", rd0, 0);
  endtask

  task automatic t_size;
    wr(OFS_SIZE, 32'd31); rd(OFS_SIZE); chk("R2 clamp", rd0, 32'd19);
    wr(OFS_SIZE, 32'd3);  rd(OFS_SIZE); chk("R2 size 3", rd0, 32'd3);
    wr(OFS_SIZE, 32'd2);  rd(OFS_SIZE); chk("R2 size 2", rd0, 32'd2);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 3; i++) pulse(1, 0, 0, 0);
    chk("R5 not full at 3", full0, 0); chk("R4 not empty", empty0, 0);
    pulse(1, 0, 0, 0);
    chk("R5 full at 4", full0, 1); chk("R5 full cmd", full1, 1);
    rd(OFS_PROD); chk("R6 prod 4", rd0, 32'd4);
    pulse(1, 0, 0, 0);
    rd(OFS_PROD);
    chk("R9 evt prod ovf", rd0, 32'h8000_0004);
    chk("R9 cmd prod no ovf", rd1, 32'h0000_0004);
    chk("R9 overflow_o", ovf0, 1); chk("R9 cmd overflow_o", ovf1, 0);
  endtask

  task automatic t_addr;
    wr(OFS_BASE_LO, 32'h1234_567F);
    wr(OFS_BASE_HI, 32'hFFFF_ABCD);
    chk("R11 prod addr slot0", pa0, BASE_M);
    pulse(0, 1, 0, 0);
    chk("R11 evt cons addr", ca0, BASE_M + 48'h20);
    chk("R11 cmd cons addr", ca1, BASE_M + 48'h10);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 3; i++) pulse(0, 1, 0, 0);
    chk("R4 empty after drain", empty0, 1);
    rd(OFS_CONS); chk("R6 cons wrap bit", rd0, 32'd4);
    for (int i = 0; i < 4; i++) pulse(1, 0, 0, 0);
    rd(OFS_PROD); chk("R6 prod through zero", rd1, 32'd0);
    chk("R5 full after wrap", full0, 1);
  endtask

  task automatic t_err;
    pulse(0, 0, 1, CQ_ERR_ABORT);
    rd(OFS_CONS); chk("R8 err abort", rd0, 32'h0200_0004);
    pulse(0, 1, 0, 0);
    rd(OFS_CONS); chk("R7 err kept on inc", rd0, 32'h0200_0005);
    for (int i = 0; i < 3; i++) pulse(0, 1, 0, 0);
    chk("R4 empty", empty0, 1);
    pulse(0, 1, 0, 0);
    rd(OFS_CONS); chk("R10 inc on empty ignored", rd0, 32'h0200_0000);
    pulse(0, 0, 1, CQ_ERR_SYNC);
    rd(OFS_CONS); chk("R8 err sync", rd1, 32'h0300_0000);
    pulse(0, 0, 1, CQ_ERR_NONE);
    rd(OFS_CONS); chk("R8 err none", rd0, 32'h0000_0000);
    pulse(0, 0, 1, CQ_ERR_ILLEGAL);
    rd(OFS_CONS); chk("R8 err illegal", rd0, 32'h0100_0000);
  endtask

  task automatic t_write;
    wr(OFS_PROD, 32'h0000_0003);
    rd(OFS_PROD); chk("R12 prod write clears ovf", rd0, 32'd3);
    chk("R12 overflow_o cleared", ovf0, 0);
    wr(OFS_CONS, 32'hFFFF_FFF7);
    rd(OFS_CONS); chk("R12 cons write keeps err", rd0, 32'h0100_0007);
    chk("R5 full slot eq wrap diff", full0, 1);
    @(negedge clk); we = 1'b1; addr = OFS_PROD; wdata = 32'd1; pinc = 1'b1;
    @(negedge clk); we = 1'b0; pinc = 1'b0;
    rd(OFS_PROD); chk("R12 write beats inc", rd0, 32'd1);
  endtask

  task automatic t_resize;
    wr(OFS_PROD, 32'h8000_0002);
    rd(OFS_PROD); chk("R12 evt ovf load", rd0, 32'h8000_0002);
    chk("R9 cmd bit31 zero", rd1, 32'h0000_0002);
    wr(OFS_SIZE, 32'd2);
    rd(OFS_PROD); chk("R3 same size keeps", rd0, 32'h8000_0002);
    wr(OFS_SIZE, 32'd4);
    rd(OFS_PROD); chk("R3 resize clears prod", rd0, 32'd0);
    rd(OFS_CONS); chk("R3 resize clears cons", rd0, 32'h0100_0000);
    chk("R3 resize clears ovf", ovf0, 0);
    for (int i = 0; i < 5; i++) pulse(1, 0, 0, 0);
    chk("R11 evt prod addr slot5", pa0, BASE_M + 48'hA0);
    chk("R11 cmd prod addr slot5", pa1, BASE_M + 48'h50);
    chk("R11 cons addr slot0", ca0, BASE_M);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_size();
    t_fill();
    t_addr();
    t_wrap();
    t_err();
    t_write();
    t_resize();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule